// File: doc/BRIEF.md
# Two-Register Data Stack

This block is the operand stack of a small 16-bit stack-machine core. The two most recently used operands sit in registers: the top in the T register and the one below it in the N register. Everything deeper lives in a memory stack of 32 words. The word currently on top of that memory is always presented on its own output, so a core sees three operands every cycle without a memory access.

The surrounding core drives a per-cycle control word. Each cycle it can load T from an external bus, load N from T or from the memory top, push a chosen register (N or T) onto the memory stack, pop the memory stack, or do both at once. Asserting push and pop together overwrites the memory top in place. Every register samples the old values at the same clock edge. Because of that, stack shuffles such as rotate, swap, over, nip and tuck each finish in one cycle. The core supplies the T-input bus itself, for example by feeding N or the memory top back into it.

Top module: `tn_data_stack`

## Requirements
- R1: While `rst` is high at a rising edge, `top_q`, `next_q` and `third_q` become 0, `empty` becomes 1 and `full` becomes 0.
- R2: `top_q` takes the value of `t_in` at a rising edge when `t_load` is 1, and keeps its value when `t_load` is 0.
- R3: When `n_load` is 1, `next_q` loads according to `n_src`: code 0 loads the old `top_q`, code 1 loads the old `third_q`, codes 2 and 3 keep its value. When `n_load` is 0, `next_q` keeps its value.
- R4: Push without pop while not full writes the selected word as the new memory top and raises depth by one. `mem_src` = 0 selects the old `next_q` and `mem_src` = 1 selects the old `top_q`. The new top appears on `third_q` after the edge, and `empty` falls.
- R5: Pop without push while not empty discards the memory top. `third_q` then shows the next-deeper word, so words come back in reverse order of pushing.
- R6: Push and pop together while not empty overwrite the memory top with the selected word and leave the depth unchanged.
- R7: `full` is 1 exactly when the memory stack holds 32 words. A push without pop while full is ignored and changes no stored word.
- R8: A pop while empty is ignored. A push and pop together while empty are also ignored, and the stack stays empty.
- R9: `third_q` reads 0 whenever the memory stack is empty, including right after the last word is popped.
- R10: All registers update at the same edge from pre-edge values. Rotate up (T from memory top, N from T, memory top overwritten with N) and rotate down (T from N, N from memory top, memory top overwritten with T) each complete in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| t_load | input | 1 | Load T from `t_in` |
| n_load | input | 1 | Load N from the source chosen by `n_src` |
| n_src | input | 2 | N source: 0 = T, 1 = memory top, 2/3 = hold |
| mem_src | input | 1 | Word pushed or overwritten: 0 = N, 1 = T |
| push | input | 1 | Push the selected word onto the memory stack |
| pop | input | 1 | Pop the memory stack |
| t_in | input | 16 | Data bus into T, driven by the core |
| top_q | output | 16 | T register |
| next_q | output | 16 | N register |
| third_q | output | 16 | Word on top of the memory stack (0 when empty) |
| full | output | 1 | Memory stack holds 32 words |
| empty | output | 1 | Memory stack holds no word |

## Verification
The assertions assume that control inputs are steady around the rising edge. They also assume the core may raise push or pop at any depth, including full and empty, relying on the block to ignore them there. Apart from that, inputs are free. The directed stimulus changes inputs only at falling edges and deliberately drives push into a full stack and pop or push-plus-pop into an empty one. Rotations are built by feeding the observed outputs back through `t_in`, the same way the core's T-input selector would.

// File: rtl/tnds_pkg.sv
package tnds_pkg;

  // What the memory stack does in a given cycle.
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2,
    ACT_REPL = 2'd3
  } stk_act_e;

  // Source codes for the N register.
  localparam logic [1:0] NSRC_TOP   = 2'd0;
  localparam logic [1:0] NSRC_THIRD = 2'd1;

endpackage

// File: rtl/tnds_ptr.sv
module tnds_ptr
  import tnds_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output stk_act_e      act,
  output logic          drain,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty
);

  logic [CW-1:0] count;
  logic [CW-1:0] nxt_count;
  logic [CW-1:0] wr_full;
  logic [CW-1:0] rd_full;

  always_comb begin
    act = ACT_NONE;
    if (push && !pop && !full)      act = ACT_PUSH;
    else if (pop && !push && !empty) act = ACT_POP;
    else if (push && pop && !empty)  act = ACT_REPL;
  end

  always_comb begin
    unique case (act)
      ACT_PUSH: nxt_count = count + CW'(1);
      ACT_POP:  nxt_count = count - CW'(1);
      default:  nxt_count = count;
    endcase
  end

  assign drain   = (act == ACT_POP) && (count == CW'(1));
  assign wr_en   = (act == ACT_PUSH) || (act == ACT_REPL);
  assign wr_full = (act == ACT_PUSH) ? count : count - CW'(1);
  assign wr_addr = wr_full[AW-1:0];
  // Look-ahead: word just below the memory top after this edge.
  assign rd_full = nxt_count - CW'(2);
  assign rd_addr = rd_full[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      count <= nxt_count;
      full  <= (nxt_count == CW'(DEPTH));
      empty <= (nxt_count == '0);
    end
  end

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (count == $past(count) + CW'(1)) && !empty);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> full && $stable(count));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> empty);

  assert_replace_keeps_depth_R6: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));

endmodule

// File: rtl/tnds_mem.sv
module tnds_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/tnds_regs.sv
module tnds_regs
  import tnds_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         t_load,
  input  logic         n_load,
  input  logic [1:0]   n_src,
  input  logic         mem_src,
  input  logic [W-1:0] t_in,
  input  stk_act_e     act,
  input  logic         drain,
  input  logic [W-1:0] below,
  output logic [W-1:0] wdata,
  output logic [W-1:0] top_q,
  output logic [W-1:0] next_q,
  output logic [W-1:0] third_q
);

  assign wdata = mem_src ? top_q : next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q   <= '0;
      next_q  <= '0;
      third_q <= '0;
    end else begin
      if (t_load) top_q <= t_in;
      if (n_load) begin
        if (n_src == NSRC_TOP)        next_q <= top_q;
        else if (n_src == NSRC_THIRD) next_q <= third_q;
      end
      unique case (act)
        ACT_PUSH, ACT_REPL: third_q <= wdata;
        ACT_POP:            third_q <= drain ? '0 : below;
        default:            ;
      endcase
    end
  end

  assert_t_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !t_load |=> $stable(top_q));

  assert_t_take_R2: assert property (@(posedge clk) disable iff (rst)
    t_load |=> (top_q == $past(t_in)));

  assert_n_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!n_load || n_src[1]) |=> $stable(next_q));

  assert_push_top_R4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_PUSH) |=> (third_q == $past(mem_src ? top_q : next_q)));

endmodule

// File: rtl/tn_data_stack.sv
module tn_data_stack
  import tnds_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         t_load,
  input  logic         n_load,
  input  logic [1:0]   n_src,
  input  logic         mem_src,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] t_in,
  output logic [W-1:0] top_q,
  output logic [W-1:0] next_q,
  output logic [W-1:0] third_q,
  output logic         full,
  output logic         empty
);

  stk_act_e      act;
  logic          drain;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  below;

  tnds_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .act(act), .drain(drain), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .full(full), .empty(empty)
  );

  tnds_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wdata), .rd_addr(rd_addr), .rd_data(below)
  );

  tnds_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .t_load(t_load), .n_load(n_load),
    .n_src(n_src), .mem_src(mem_src), .t_in(t_in),
    .act(act), .drain(drain), .below(below), .wdata(wdata),
    .top_q(top_q), .next_q(next_q), .third_q(third_q)
  );

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    empty |-> (third_q == '0));

  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> !full);

endmodule

// File: tb/tb_tn_data_stack.sv
module tb_tn_data_stack;

  localparam int W = 16;
  localparam int DEPTH = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         t_load = 1'b0, n_load = 1'b0, mem_src = 1'b0, push = 1'b0, pop = 1'b0;
  logic [1:0]   n_src = 2'd0;
  logic [W-1:0] t_in = '0;
  logic [W-1:0] top_q, next_q, third_q;
  logic         full, empty;

  int checks = 0;
  int fails  = 0;

  // Bench model, built from the requirements.
  logic [W-1:0] m_t, m_n;
  logic [W-1:0] m_stk [DEPTH];
  int           m_cnt;

  always #4 clk = ~clk;

  tn_data_stack #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .t_load(t_load), .n_load(n_load), .n_src(n_src),
    .mem_src(mem_src), .push(push), .pop(pop), .t_in(t_in),
    .top_q(top_q), .next_q(next_q), .third_q(third_q),
    .full(full), .empty(empty)
  );

  function automatic logic [W-1:0] m_third();
    return (m_cnt > 0) ? m_stk[m_cnt-1] : '0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act_v, input logic [W-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " T"}, top_q, m_t);
    chk({tag, " N"}, next_q, m_n);
    chk({tag, " N2"}, third_q, m_third());
    chk({tag, " full"}, {15'd0, full}, {15'd0, m_cnt == DEPTH});
    chk({tag, " empty"}, {15'd0, empty}, {15'd0, m_cnt == 0});
  endtask

  // One cycle: drive at falling edge, update model, sample at next falling edge.
  task automatic step(input logic tl, input logic nl, input logic [1:0] ns,
                      input logic ms, input logic pu, input logic po,
                      input logic [W-1:0] ti);
    logic [W-1:0] ot, on, o3, w;
    ot = m_t; on = m_n; o3 = m_third();
    w = ms ? ot : on;
    if (tl) m_t = ti;
    if (nl) begin
      if (ns == 2'd0) m_n = ot;
      else if (ns == 2'd1) m_n = o3;
    end
    if (pu && !po && m_cnt < DEPTH) begin
      m_stk[m_cnt] = w; m_cnt++;
    end else if (po && !pu && m_cnt > 0) begin
      m_cnt--;
    end else if (pu && po && m_cnt > 0) begin
      m_stk[m_cnt-1] = w;
    end
    t_load = tl; n_load = nl; n_src = ns; mem_src = ms; push = pu; pop = po; t_in = ti;
    @(posedge clk);
    @(negedge clk);
    t_load = 0; n_load = 0; n_src = 0; mem_src = 0; push = 0; pop = 0; t_in = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_t = '0; m_n = '0; m_cnt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_tload();
    step(0, 0, 0, 0, 0, 0, 16'hDEAD);
    chk("R2 T hold", top_q, 16'h0000);
    step(1, 0, 0, 0, 0, 0, 16'h1234);
    chk("R2 T load", top_q, 16'h1234);
  endtask

  task automatic t_nload();
    step(0, 0, 2'd0, 0, 0, 0, '0);
    chk("R3 N hold n_load low", next_q, 16'h0000);
    step(0, 1, 2'd0, 0, 0, 0, '0);
    chk("R3 N from T", next_q, 16'h1234);
    step(1, 0, 0, 0, 0, 0, 16'h5555);
    step(0, 1, 2'd2, 0, 0, 0, '0);
    chk("R3 N hold code2", next_q, 16'h1234);
    step(0, 1, 2'd3, 0, 0, 0, '0);
    chk("R3 N hold code3", next_q, 16'h1234);
    chk_all("R3 state");
  endtask

  task automatic t_push();
    step(0, 0, 0, 0, 1, 0, '0);
    chk("R4 push N", third_q, 16'h1234);
    chk("R4 empty falls", {15'd0, empty}, 16'd0);
    step(0, 0, 0, 1, 1, 0, '0);
    chk("R4 push T", third_q, 16'h5555);
    step(0, 1, 2'd1, 0, 0, 0, '0);
    chk("R3 N from N2", next_q, 16'h5555);
    chk_all("R4 state");
  endtask

  task automatic t_pop();
    step(1, 0, 0, 0, 0, 0, 16'h0A0A);
    step(0, 0, 0, 1, 1, 0, '0);
    step(0, 0, 0, 0, 0, 1, '0);
    chk("R5 pop reveals", third_q, 16'h5555);
    step(0, 0, 0, 0, 0, 1, '0);
    chk("R5 pop reveals deeper", third_q, 16'h1234);
    chk_all("R5 state");
  endtask

  task automatic t_replace();
    step(1, 0, 0, 0, 0, 0, 16'hBEEF);
    step(0, 0, 0, 1, 1, 1, '0);
    chk("R6 overwrite top", third_q, 16'hBEEF);
    chk_all("R6 depth kept");
    step(0, 0, 0, 0, 0, 1, '0);
    chk_all("R6 below untouched");
  endtask

  task automatic t_rotate();
    do_reset();
    step(1, 0, 0, 0, 0, 0, 16'h000A);
    step(1, 1, 2'd0, 1, 1, 0, 16'h000B);
    step(1, 1, 2'd0, 0, 1, 0, 16'h000C);
    step(0, 1, 2'd0, 0, 1, 0, '0);
    // rotate up: T<-N2, N<-T, N2<-N
    step(1, 1, 2'd0, 0, 1, 1, third_q);
    chk_all("R10 rotate up");
    // rotate down: T<-N, N<-N2, N2<-T
    step(1, 1, 2'd1, 1, 1, 1, next_q);
    chk_all("R10 rotate down");
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, 1, 0, 16'h0100 + 16'(i));
    chk("R7 full set", {15'd0, full}, 16'd1);
    chk_all("R7 at depth");
    step(1, 0, 0, 1, 1, 0, 16'h7777);
    chk("R7 push ignored N2", third_q, 16'h0100 + 16'(DEPTH - 2));
    chk_all("R7 after ignored push");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 0, 1, '0);
      chk_all("R5 drain order");
    end
    chk("R9 N2 zero drained", third_q, 16'h0000);
  endtask

  task automatic t_empty();
    step(0, 0, 0, 0, 0, 1, '0);
    chk_all("R8 pop empty");
    step(1, 0, 0, 1, 1, 1, 16'h4242);
    chk("R8 repl empty stays empty", {15'd0, empty}, 16'd1);
    chk("R9 N2 zero", third_q, 16'h0000);
    chk_all("R8 state");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_tload();
    t_nload();
    t_push();
    t_pop();
    t_replace();
    t_rotate();
    t_full();
    t_empty();
    step(1, 1, 2'd0, 1, 1, 0, 16'h9999);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule